// File: doc/BRIEF.md
# Multiprocessor Glue Control Registers

This block is a small memory-mapped register window that firmware on a multiprocessor system uses for chores no ordinary peripheral covers. A write to the halt register asks the system to stop. The byte written becomes the exit status. A read of the identity register tells a processor its own index, which the block takes from the requester-ID field of the access. A read of the count register reports how many processors are active, as set by a configuration strap. A write to the interrupt-steering register raises or lowers the level-sensitive external interrupt line of one chosen processor.

Interrupt steering uses a single store of two or more bytes. The lowest byte names the target line and the next byte gives the level. Any nonzero level byte drives the line high, and a zero byte drives it low. The level then stays on that line until a later steering write names the same line again. Only the low six address bits take part in decoding, so the window repeats every 64 bytes. Read data returns one cycle after the read is presented, together with a one-cycle valid flag.

Top module: `mp_glue_regs`

## Requirements
- R1: After reset, every interrupt line is 0, the halt strobe is 0, the exit code is 0 and the read-valid flag is 0.
- R2: A write to offset 0, of any size, raises the halt strobe for exactly the one cycle after the write and loads the exit code from data bits [7:0]. The exit code holds that value afterwards.
- R3: A read of offset 4 returns the requester ID of that same access, zero-extended, on the read-data port in the cycle after the read, with read-valid high.
- R4: A write to offset 8 with size code 1 (two bytes) or 2 (four bytes) drives the line numbered by data bits [7:0]. The line goes to 1 if data bits [15:8] are nonzero and to 0 if they are zero. The new level appears in the cycle after the write.
- R5: An interrupt line keeps its level until a later accepted steering write selects that same line. Writes that select other lines leave it as it is.
- R6: A write to offset 8 with size code 0 (one byte) drives the selected line to 0, whatever data bits [15:8] hold.
- R7: A steering write whose port number is not below both NUM_CPU and the processor-count strap changes no interrupt line.
- R8: A read of offset 12 returns the processor-count strap, zero-extended. A strap of 0, meaning no count is configured, reads back as 0.
- R9: Only address bits [5:0] select a register, so an access at offset plus 64 behaves exactly like one at the offset itself.
- R10: A read of any offset other than 4 or 12 returns 0 with read-valid high. This includes the write-only offsets 0 and 8. A read never raises the halt strobe or changes a line. A write to offset 4, 12 or an unmapped offset changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Access presented this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address; bits [5:0] decoded |
| busSize | input | 2 | 0 = one byte, 1 = two bytes, 2 = four bytes |
| busWdata | input | DATA_W | Write data, lowest byte in bits [7:0] |
| busReqId | input | ID_W | Index of the requesting processor |
| cpuCountCfg | input | 8 | Active processor count strap, 0 = not configured |
| busRdata | output | DATA_W | Read data, one cycle after the read |
| rdValid | output | 1 | Read data valid this cycle |
| irqLevel | output | NUM_CPU | Level-sensitive interrupt line per processor |
| haltPulse | output | 1 | One-cycle halt request |
| exitCode | output | 8 | Exit status from the last halt write |

## Verification
The hardest cases to reach from the ports are a line holding its level while other lines are rewritten, and a steering write that names a port just past the limit. The limit counts only when the strap is below NUM_CPU. The stimulus sets two lines and toggles a third while checking the first two. It then lowers the strap at run time and aims writes both at the new boundary and just below it. A one-byte steering write that carries a nonzero level byte, and reads of the write-only offsets, show that the size code and read direction decide the outcome and the data byte does not.

// File: rtl/mp_glue_pkg.sv
package mp_glue_pkg;

  localparam int DEC_W = 6;

  localparam logic [DEC_W-1:0] OFS_HALT  = 6'd0;
  localparam logic [DEC_W-1:0] OFS_CPUID = 6'd4;
  localparam logic [DEC_W-1:0] OFS_IRQ   = 6'd8;
  localparam logic [DEC_W-1:0] OFS_COUNT = 6'd12;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } busSize_e;

  typedef struct packed {
    logic haltWr;
    logic irqWr;
    logic irqWide;
    logic rdId;
    logic rdCount;
    logic rdAny;
  } ctrlStrb_t;

endpackage

// File: rtl/mp_glue_ctrl.sv
module mp_glue_ctrl
  import mp_glue_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  output ctrlStrb_t         strb
);

  logic [DEC_W-1:0] offs;
  logic             wrAcc;
  logic             rdAcc;

  assign offs  = busAddr[DEC_W-1:0];
  assign wrAcc = busValid && busWrite;
  assign rdAcc = busValid && !busWrite;

  generate
    if (ADDR_W > DEC_W) begin : g_hi
      logic unusedHiAddr;
      assign unusedHiAddr = ^busAddr[ADDR_W-1:DEC_W];
    end
  endgenerate

  always_comb begin
    strb         = '0;
    strb.haltWr  = wrAcc && (offs == OFS_HALT);
    strb.irqWr   = wrAcc && (offs == OFS_IRQ);
    strb.irqWide = busSize != SZ_BYTE;
    strb.rdId    = rdAcc && (offs == OFS_CPUID);
    strb.rdCount = rdAcc && (offs == OFS_COUNT);
    strb.rdAny   = rdAcc;
  end

endmodule

// File: rtl/mp_glue_dp.sv
module mp_glue_dp
  import mp_glue_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [ID_W-1:0]    busReqId,
  input  logic [7:0]         cpuCountCfg,
  output logic [DATA_W-1:0]  busRdata,
  output logic               rdValid,
  output logic [NUM_CPU-1:0] irqLevel,
  output logic               haltPulse,
  output logic [7:0]         exitCode
);

  localparam logic [7:0] CPU_LIMIT = 8'(NUM_CPU);

  logic [7:0]        portSel;
  logic [7:0]        levelByte;
  logic              newLevel;
  logic              portOk;
  logic [DATA_W-1:0] rdMux;
  logic              unusedWdata;

  assign portSel     = busWdata[7:0];
  assign levelByte   = busWdata[15:8];
  assign newLevel    = strb.irqWide && (levelByte != 8'd0);
  assign portOk      = (portSel < CPU_LIMIT) && (portSel < cpuCountCfg);
  assign unusedWdata = ^busWdata[DATA_W-1:16];

  generate
    for (genvar i = 0; i < NUM_CPU; i++) begin : g_irq
      always_ff @(posedge clk) begin
        if (!rstN) begin
          irqLevel[i] <= 1'b0;
        end else if (strb.irqWr && portOk && (portSel == 8'(i))) begin
          irqLevel[i] <= newLevel;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haltPulse <= 1'b0;
      exitCode  <= 8'd0;
    end else begin
      haltPulse <= strb.haltWr;
      if (strb.haltWr) exitCode <= busWdata[7:0];
    end
  end

  always_comb begin
    rdMux = '0;
    if (strb.rdId)         rdMux = DATA_W'(busReqId);
    else if (strb.rdCount) rdMux = DATA_W'(cpuCountCfg);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid  <= 1'b0;
      busRdata <= '0;
    end else begin
      rdValid  <= strb.rdAny;
      busRdata <= rdMux;
    end
  end

  // R7
  irq_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.irqWr && !portOk) |=> $stable(irqLevel));

  // R10
  rd_nohalt_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdAny |=> !haltPulse);

endmodule

// File: rtl/mp_glue_regs.sv
module mp_glue_regs
  import mp_glue_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [1:0]         busSize,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [ID_W-1:0]    busReqId,
  input  logic [7:0]         cpuCountCfg,
  output logic [DATA_W-1:0]  busRdata,
  output logic               rdValid,
  output logic [NUM_CPU-1:0] irqLevel,
  output logic               haltPulse,
  output logic [7:0]         exitCode
);

  ctrlStrb_t strb;

  mp_glue_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busValid(busValid),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .busSize (busSize),
    .strb    (strb)
  );

  mp_glue_dp #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W), .ID_W(ID_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busWdata   (busWdata),
    .busReqId   (busReqId),
    .cpuCountCfg(cpuCountCfg),
    .busRdata   (busRdata),
    .rdValid    (rdValid),
    .irqLevel   (irqLevel),
    .haltPulse  (haltPulse),
    .exitCode   (exitCode)
  );

  logic [DEC_W-1:0] chkOffs;
  logic             chkIrqWr;
  assign chkOffs  = busAddr[DEC_W-1:0];
  assign chkIrqWr = busValid && busWrite && (chkOffs == OFS_IRQ);

  // R2
  halt_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    haltPulse |-> $past(busValid && busWrite && (chkOffs == OFS_HALT)));

  // R2
  halt_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    haltPulse |-> (exitCode == $past(busWdata[7:0])));

  // R3
  rd_id_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && (chkOffs == OFS_CPUID))
      |=> (rdValid && (busRdata == DATA_W'($past(busReqId)))));

  // R5
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chkIrqWr |=> $stable(irqLevel));

  // R10
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && (chkOffs != OFS_CPUID) && (chkOffs != OFS_COUNT))
      |=> (rdValid && (busRdata == '0)));

endmodule

// File: tb/mp_glue_regs_tb.sv
module mp_glue_regs_tb;

  localparam int NUM_CPU = 4;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int ID_W    = 4;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               busValid = 1'b0;
  logic               busWrite = 1'b0;
  logic [ADDR_W-1:0]  busAddr = '0;
  logic [1:0]         busSize = 2'd0;
  logic [DATA_W-1:0]  busWdata = '0;
  logic [ID_W-1:0]    busReqId = '0;
  logic [7:0]         cpuCountCfg = 8'd4;
  logic [DATA_W-1:0]  busRdata;
  logic               rdValid;
  logic [NUM_CPU-1:0] irqLevel;
  logic               haltPulse;
  logic [7:0]         exitCode;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  typedef struct { logic [DATA_W-1:0] value; string tag; } expItem_t;
  expItem_t expQ[$];

  always #5 clk = ~clk;

  mp_glue_regs #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata), .busReqId(busReqId),
    .cpuCountCfg(cpuCountCfg), .busRdata(busRdata), .rdValid(rdValid),
    .irqLevel(irqLevel), .haltPulse(haltPulse), .exitCode(exitCode)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data when the design flags it valid.
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10 unexpected read-valid", 64'(busRdata), 64'd0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(busRdata == it.value, it.tag, 64'(busRdata), 64'(it.value));
      end
    end
  end

  task automatic busAcc(input bit wr, input logic [ADDR_W-1:0] addr, input logic [1:0] size,
                        input logic [DATA_W-1:0] wdata, input logic [ID_W-1:0] rid);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = addr; busSize = size;
    busWdata = wdata; busReqId = rid;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic readExp(input logic [ADDR_W-1:0] addr, input logic [ID_W-1:0] rid,
                         input logic [DATA_W-1:0] exp, input string tag);
    expItem_t it;
    it.value = exp; it.tag = tag;
    expQ.push_back(it);
    busAcc(1'b0, addr, 2'd2, 32'hDEAD_BEEF, rid);
  endtask

  task automatic steer(input logic [ADDR_W-1:0] addr, input logic [1:0] size,
                       input logic [7:0] port, input logic [7:0] lvl);
    busAcc(1'b1, addr, size, {16'hA5A5, lvl, port}, '0);
  endtask

  task automatic irqIs(input logic [NUM_CPU-1:0] exp, input string tag);
    check(irqLevel == exp, tag, 64'(irqLevel), 64'(exp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(irqLevel == '0, "R1 irq at reset", 64'(irqLevel), 64'd0);
    check(!haltPulse, "R1 halt at reset", 64'(haltPulse), 64'd0);
    check(exitCode == 8'd0, "R1 exit code at reset", 64'(exitCode), 64'd0);
    check(!rdValid, "R1 read-valid at reset", 64'(rdValid), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 processor identity follows the requester
    readExp(8'd4, 4'd3, 32'd3, "R3 id=3");
    readExp(8'd4, 4'd0, 32'd0, "R3 id=0");
    readExp(8'd4, 4'd15, 32'd15, "R3 id=15");
    // R8 count strap
    readExp(8'd12, 4'd1, 32'd4, "R8 count=4");

    // R4 two-byte steering
    steer(8'd8, 2'd1, 8'd2, 8'd1);
    irqIs(4'b0100, "R4 port2 high");
    steer(8'd8, 2'd2, 8'd0, 8'h80);
    irqIs(4'b0101, "R4 port0 high word write");
    // R5 hold other lines while port2 toggles
    steer(8'd8, 2'd1, 8'd2, 8'd0);
    irqIs(4'b0001, "R5 port0 held, port2 low");
    steer(8'd8, 2'd1, 8'd3, 8'd7);
    irqIs(4'b1001, "R5 port0 held, port3 high");
    // R6 one-byte write drives 0 despite level byte
    steer(8'd8, 2'd0, 8'd0, 8'hFF);
    irqIs(4'b1000, "R6 byte write forces 0");
    // R7 port beyond NUM_CPU ignored
    steer(8'd8, 2'd1, 8'd4, 8'd1);
    irqIs(4'b1000, "R7 port4 ignored");
    steer(8'd8, 2'd1, 8'd200, 8'd1);
    irqIs(4'b1000, "R7 port200 ignored");
    // R7 strap lowers the limit
    cpuCountCfg = 8'd2;
    steer(8'd8, 2'd1, 8'd2, 8'd1);
    irqIs(4'b1000, "R7 port2 ignored with count 2");
    steer(8'd8, 2'd1, 8'd3, 8'd0);
    irqIs(4'b1000, "R7 port3 clear ignored with count 2");
    steer(8'd8, 2'd1, 8'd1, 8'd1);
    irqIs(4'b1010, "R7 port1 accepted with count 2");
    readExp(8'd12, 4'd0, 32'd2, "R8 count=2");
    cpuCountCfg = 8'd0;
    readExp(8'd12, 4'd0, 32'd0, "R8 unconfigured count");
    steer(8'd8, 2'd1, 8'd1, 8'd0);
    irqIs(4'b1010, "R7 all ports ignored with count 0");
    cpuCountCfg = 8'd4;

    // R9 aliasing above bit 5
    readExp(8'd68, 4'd9, 32'd9, "R9 alias id");
    steer(8'd72, 2'd1, 8'd0, 8'd1);
    irqIs(4'b1011, "R9 alias steering");
    readExp(8'd140, 4'd0, 32'd4, "R9 alias count");

    // R10 zero reads and no side effects
    readExp(8'd0, 4'd2, 32'd0, "R10 read halt offset");
    check(!haltPulse, "R10 read no halt", 64'(haltPulse), 64'd0);
    readExp(8'd8, 4'd2, 32'd0, "R10 read steer offset");
    readExp(8'd16, 4'd2, 32'd0, "R10 read unmapped 16");
    readExp(8'd60, 4'd2, 32'd0, "R10 read unmapped 60");
    irqIs(4'b1011, "R10 reads leave lines");
    busAcc(1'b1, 8'd4, 2'd1, 32'h0000_0001, 4'd0);
    busAcc(1'b1, 8'd12, 2'd1, 32'h0000_0102, 4'd0);
    busAcc(1'b1, 8'd20, 2'd1, 32'h0000_0103, 4'd0);
    irqIs(4'b1011, "R10 writes elsewhere leave lines");
    check(!haltPulse && exitCode == 8'd0, "R10 writes elsewhere no halt", 64'(exitCode), 64'd0);

    // R2 halt strobe
    busAcc(1'b1, 8'd0, 2'd0, 32'h1234_565A, 4'd0);
    check(haltPulse, "R2 halt pulse", 64'(haltPulse), 64'd1);
    check(exitCode == 8'h5A, "R2 exit code", 64'(exitCode), 64'h5A);
    @(negedge clk);
    check(!haltPulse, "R2 pulse one cycle", 64'(haltPulse), 64'd0);
    check(exitCode == 8'h5A, "R2 exit code held", 64'(exitCode), 64'h5A);
    busAcc(1'b1, 8'd64, 2'd2, 32'h0000_00C3, 4'd0);
    check(haltPulse && exitCode == 8'hC3, "R2 alias halt new code", 64'(exitCode), 64'hC3);

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R3 all reads answered", 64'(expQ.size()), 64'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule